// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache with First-In-First-Out Replacement

This block is a small data cache between a processor and a slower word-wide memory. It holds 64 bytes in two sets of two ways, with 16-byte lines of two 64-bit words each. The processor issues one 64-bit load or store at a time. The cache answers each request with a single response pulse that also reports whether the request hit.

Stores that hit change only the cached copy, and the line is marked dirty. A miss of either kind fetches the whole line before the request completes; a store miss then merges its data into the fetched line. When the replaced line is dirty, both of its words go back to memory before the new line is read. Within a set, an empty way is used first. Once both ways are full, the way that was filled earlier is replaced, however recently it was used.

The memory side moves one word per handshake. The cache holds a request until the memory acknowledges it with a one-cycle pulse.

Top module: `fifo_wb_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses. While idle, `req_ready` is 1, `resp_valid` is 0 and `mem_req` is 0.
- R2: Geometry is two sets × two ways × 16-byte lines, each line holding two 64-bit words. Request addresses are 8-byte aligned. Address bit 3 selects the word, bit 4 selects the set, and bits 31..5 form the tag.
- R3: A load that hits responds with `resp_hit`=1 and the cached word on the second rising edge after acceptance, with no memory transaction.
- R4: A load that misses reads the line from memory as two reads, first the word at line offset 0 and then the one at offset 8. It then responds with `resp_hit`=0 and the requested word.
- R5: A store that hits writes only the cached word, with no memory transaction, and marks the line dirty. A later load of that word hits and returns the stored value.
- R6: A store that misses reads both words of its line from memory, merges the store data and responds with `resp_hit`=0. It does not write the store data to memory, and the line is left dirty.
- R7: A miss fills an invalid way of its set before any valid way is replaced. After reset, two distinct lines of one set both stay resident.
- R8: When both ways of a set are valid, a miss replaces the way filled earlier. Hits do not change this order.
- R9: A dirty victim is written to memory as two writes, offset 0 then offset 8, at the victim's own address, before the refill reads start. A clean victim causes no writes. Memory therefore always holds the latest value of every evicted word.
- R10: Once `mem_req` is raised, it stays high with `mem_we`, `mem_addr` and `mem_wdata` unchanged until the cycle in which `mem_ack` is 1. Each handshake moves one word.
- R11: `req_ready` is low from the accepting edge until the response. `resp_valid` is a one-cycle pulse, given exactly once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present; taken when `req_ready` is 1 |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address, 8-byte aligned |
| req_wdata | input | 64 | Store data |
| req_ready | output | 1 | Cache idle and able to take a request |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | 1 when the completed request hit |
| resp_rdata | output | 64 | Load result, valid with `resp_valid` for loads |
| mem_req | output | 1 | Memory word transfer requested |
| mem_we | output | 1 | 1 = write to memory, 0 = read |
| mem_addr | output | 32 | Word address for the transfer |
| mem_wdata | output | 64 | Data for a memory write |
| mem_ack | input | 1 | One-cycle acknowledge that completes the transfer |
| mem_rdata | input | 64 | Read data, valid while `mem_ack` is 1 |

## Verification
The assertions take four things for granted about the inputs:
- Request addresses are 8-byte aligned.
- `req_valid` is raised only while `req_ready` is high.
- The memory raises `mem_ack` only while `mem_req` is high, and only for one cycle.
- `mem_rdata` is valid in the acknowledge cycle.

The stimulus stays within these limits. It issues word-aligned addresses from a 256-byte window and holds each request for exactly one accepted cycle. Its memory model answers each raised `mem_req` with a single acknowledge pulse after zero to three wait cycles, where the wait varies from request to request.

// File: rtl/cache_pkg.sv
package cache_pkg;

  // Controller phases; the encoding is free, the order of visits is fixed:
  // idle -> lookup -> (writeback ->) refill -> idle
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_LOOKUP    = 2'd1,
    ST_WRITEBACK = 2'd2,
    ST_REFILL    = 2'd3
  } cache_state_t;

endpackage

// File: rtl/cache_data_ram.sv
// One way of line storage: simple dual-port array, synchronous read,
// no reset on the contents so that a block RAM can be inferred.
module cache_data_ram #(
  parameter int AW = 2,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
    q <= store_q[raddr];
  end

endmodule

// File: rtl/cache_tag_store.sv
// Tags, valid and dirty bits for two ways, plus one replacement pointer
// per set that names the way filled earliest.
module cache_tag_store #(
  parameter int SET_W = 1,
  parameter int TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst,
  // lookup
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [1:0]       hit_vec,
  output logic             victim_way,
  output logic             victim_dirty,
  output logic [TAG_W-1:0] victim_tag,
  // line fill
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic             fill_way,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_dirty,
  // store hit
  input  logic             mark_en,
  input  logic [SET_W-1:0] mark_set,
  input  logic             mark_way
);
  localparam int SETS = 1 << SET_W;

  logic [1:0]       way_valid;
  logic [1:0]       way_dirty;
  logic [1:0]       fill_valid;
  logic [TAG_W-1:0] way_tag [2];
  logic [SETS-1:0]  oldest_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  drt_q;
    logic [TAG_W-1:0] tag_q [SETS];

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= '0;
        drt_q <= '0;
      end else if (fill_en && fill_way == 1'(w)) begin
        vld_q[fill_set] <= 1'b1;
        drt_q[fill_set] <= fill_dirty;
        tag_q[fill_set] <= fill_tag;
      end else if (mark_en && mark_way == 1'(w)) begin
        drt_q[mark_set] <= 1'b1;
      end
    end

    assign way_valid[w]  = vld_q[lk_set];
    assign way_dirty[w]  = drt_q[lk_set];
    assign way_tag[w]    = tag_q[lk_set];
    assign fill_valid[w] = vld_q[fill_set];
    assign hit_vec[w]    = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);
  end

  // pointer moves only when a line enters the set
  always_ff @(posedge clk) begin
    if (rst) oldest_q <= '0;
    else if (fill_en) oldest_q[fill_set] <= ~oldest_q[fill_set];
  end

  always_comb begin
    if (!way_valid[0])      victim_way = 1'b0;
    else if (!way_valid[1]) victim_way = 1'b1;
    else                    victim_way = oldest_q[lk_set];
    victim_dirty = way_valid[victim_way] && way_dirty[victim_way];
    victim_tag   = way_tag[victim_way];
  end

  // a line can be resident in at most one way of its set
  assert_single_hit_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // an empty way is always chosen before an occupied one
  assert_empty_first_R7: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !fill_valid[0]) |-> (fill_way == 1'b0));

  // replacement order is untouched by anything but a fill
  assert_order_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !fill_en |=> $stable(oldest_q));

endmodule

// File: rtl/fifo_wb_cache.sv
module fifo_wb_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int BYTE_W     = $clog2(WORD_BYTES);
  localparam int WSEL_W     = $clog2(WORDS);
  localparam int SET_W      = $clog2(SETS);
  localparam int TAG_W      = ADDR_W - BYTE_W - WSEL_W - SET_W;
  localparam int RAM_AW     = SET_W + WSEL_W;
  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(WORDS - 1);

  cache_state_t state_q;

  // latched request
  logic              wr_q;
  logic [SET_W-1:0]  set_q;
  logic [TAG_W-1:0]  tag_q;
  logic [WSEL_W-1:0] word_q;
  logic [DATA_W-1:0] wdata_q;
  // miss handling
  logic              way_q;
  logic [TAG_W-1:0]  vtag_q;
  logic [WSEL_W-1:0] wcnt_q;
  logic              issued_q;

  // request address fields
  logic [WSEL_W-1:0] in_word;
  logic [SET_W-1:0]  in_set;
  logic [TAG_W-1:0]  in_tag;
  assign in_word = req_addr[BYTE_W +: WSEL_W];
  assign in_set  = req_addr[BYTE_W+WSEL_W +: SET_W];
  assign in_tag  = req_addr[ADDR_W-1 -: TAG_W];

  // tag store
  logic [1:0]       hit_vec;
  logic             any_hit, hit_way;
  logic             victim_way, victim_dirty;
  logic [TAG_W-1:0] victim_tag;
  logic             fill_en, mark_en;

  assign any_hit = |hit_vec;
  assign hit_way = hit_vec[1];

  logic xfer, last_word;
  assign xfer      = mem_req && mem_ack;
  assign last_word = (wcnt_q == LAST_WORD);

  assign fill_en = (state_q == ST_REFILL) && xfer && last_word;
  assign mark_en = (state_q == ST_LOOKUP) && wr_q && any_hit;

  cache_tag_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
    .clk          (clk),
    .rst          (rst),
    .lk_set       (set_q),
    .lk_tag       (tag_q),
    .hit_vec      (hit_vec),
    .victim_way   (victim_way),
    .victim_dirty (victim_dirty),
    .victim_tag   (victim_tag),
    .fill_en      (fill_en),
    .fill_set     (set_q),
    .fill_way     (way_q),
    .fill_tag     (tag_q),
    .fill_dirty   (wr_q),
    .mark_en      (mark_en),
    .mark_set     (set_q),
    .mark_way     (hit_way)
  );

  // line data, one array per way
  logic [1:0]        ram_we;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_q [2];

  for (genvar w = 0; w < 2; w++) begin : g_ram
    cache_data_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
      .clk   (clk),
      .we    (ram_we[w]),
      .waddr (ram_waddr),
      .wdata (ram_wdata),
      .raddr (ram_raddr),
      .q     (ram_q[w])
    );
  end

  // read address: the requested word while idle, the victim's words during
  // writeback (advanced on the acknowledge edge so the next word is ready)
  always_comb begin
    case (state_q)
      ST_IDLE:      ram_raddr = {in_set, in_word};
      ST_WRITEBACK: ram_raddr = {set_q, wcnt_q + WSEL_W'(xfer)};
      default:      ram_raddr = {set_q, {WSEL_W{1'b0}}};
    endcase
  end

  always_comb begin
    ram_we    = '0;
    ram_waddr = {set_q, word_q};
    ram_wdata = wdata_q;
    if (mark_en) begin
      ram_we[hit_way] = 1'b1;
    end else if (state_q == ST_REFILL && xfer) begin
      ram_we[way_q] = 1'b1;
      ram_waddr     = {set_q, wcnt_q};
      ram_wdata     = (wr_q && wcnt_q == word_q) ? wdata_q : mem_rdata;
    end
  end

  assign req_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      wr_q       <= 1'b0;
      set_q      <= '0;
      tag_q      <= '0;
      word_q     <= '0;
      wdata_q    <= '0;
      way_q      <= 1'b0;
      vtag_q     <= '0;
      wcnt_q     <= '0;
      issued_q   <= 1'b0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            wr_q    <= req_write;
            set_q   <= in_set;
            tag_q   <= in_tag;
            word_q  <= in_word;
            wdata_q <= req_wdata;
            state_q <= ST_LOOKUP;
          end
        end

        ST_LOOKUP: begin
          if (any_hit) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            if (!wr_q) resp_rdata <= ram_q[hit_way];
            state_q <= ST_IDLE;
          end else begin
            way_q    <= victim_way;
            vtag_q   <= victim_tag;
            wcnt_q   <= '0;
            issued_q <= 1'b0;
            state_q  <= victim_dirty ? ST_WRITEBACK : ST_REFILL;
          end
        end

        ST_WRITEBACK: begin
          if (!issued_q) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {vtag_q, set_q, wcnt_q, {BYTE_W{1'b0}}};
            mem_wdata <= ram_q[way_q];
            issued_q  <= 1'b1;
          end else if (xfer) begin
            mem_req  <= 1'b0;
            mem_we   <= 1'b0;
            issued_q <= 1'b0;
            if (last_word) begin
              wcnt_q  <= '0;
              state_q <= ST_REFILL;
            end else begin
              wcnt_q <= wcnt_q + 1'b1;
            end
          end
        end

        ST_REFILL: begin
          if (!issued_q) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= {tag_q, set_q, wcnt_q, {BYTE_W{1'b0}}};
            issued_q <= 1'b1;
          end else if (xfer) begin
            mem_req  <= 1'b0;
            issued_q <= 1'b0;
            if (!wr_q && wcnt_q == word_q) resp_rdata <= mem_rdata;
            if (last_word) begin
              wcnt_q     <= '0;
              resp_valid <= 1'b1;
              resp_hit   <= 1'b0;
              state_q    <= ST_IDLE;
            end else begin
              wcnt_q <= wcnt_q + 1'b1;
            end
          end
        end

        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // input assumption: word-aligned requests
  assert_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> (req_addr[BYTE_W-1:0] == '0));

  // a pending memory transfer is held unchanged until acknowledged
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  // writes to memory never happen while the new line is being read
  assert_no_write_in_refill_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REFILL && mem_req) |-> !mem_we);

  // a hit completes without any memory traffic
  assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> !mem_req);

  // completion is a single-cycle pulse and leaves the cache ready
  assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
  assert_resp_ready_R11: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> req_ready);

endmodule

// File: tb/test_fifo_wb_cache.sv
`timescale 1ns/1ps
module test_fifo_wb_cache;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr  = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, resp_valid, resp_hit;
  logic [63:0] resp_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack;
  logic [63:0] mem_rdata;

  always #2 clk = ~clk;   // 250 MHz

  fifo_wb_cache i_fifo_wb_cache (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [63:0] init_word(int i);
    return {32'hC0DE0000 + 32'(i), 32'(i * 37 + 5)};
  endfunction

  // ---------------- memory model: 32 words, 0..3 wait cycles ----------------
  int          lat = 0;
  logic [63:0] mem [32];
  int          wait_cnt;
  logic        log_we   [16];
  logic [7:0]  log_addr [16];
  int          log_n;

  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wait_cnt  <= 0;
      log_n     <= 0;
      for (int i = 0; i < 32; i++) mem[i] <= init_word(i);
    end else if (mem_req && !mem_ack) begin
      if (wait_cnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[7:3]];
        if (mem_we) mem[mem_addr[7:3]] <= mem_wdata;
        log_we[log_n % 16]   <= mem_we;
        log_addr[log_n % 16] <= mem_addr[7:0];
        log_n    <= log_n + 1;
        wait_cnt <= 0;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // handshake monitor (R10)
  int          hold_viol = 0;
  logic        pend;
  logic [31:0] p_addr;
  logic        p_we;
  logic [63:0] p_wd;
  always @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else begin
      if (pend && (!mem_req || mem_addr != p_addr || mem_we != p_we || mem_wdata != p_wd))
        hold_viol <= hold_viol + 1;
      pend   <= mem_req && !mem_ack;
      p_addr <= mem_addr;
      p_we   <= mem_we;
      p_wd   <= mem_wdata;
    end
  end

  // ---------------- checking ----------------
  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // reference state, built from the requirements
  logic [2:0]  m_tag  [2][2];
  bit          m_val  [2][2];
  bit          m_dirty[2][2];
  bit          m_old  [2];
  logic [63:0] m_data [2][2][2];
  logic [63:0] exp_mem[32];

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < 2; s++) begin
      m_old[s] = 1'b0;
      for (int k = 0; k < 2; k++) begin
        m_val[s][k] = 1'b0;
        m_dirty[s][k] = 1'b0;
      end
    end
    for (int i = 0; i < 32; i++) exp_mem[i] = init_word(i);
    @(negedge clk);
    check(req_ready && !resp_valid && !mem_req, "R1", "idle outputs after reset",
          {61'd0, req_ready, resp_valid, mem_req}, 64'b100);
  endtask

  task automatic do_req(input bit wr, input logic [7:0] a, input logic [63:0] wd,
                        output bit got_hit);
    int s, tg, w, vic, start, n, e_n;
    bit e_hit, rdy_bad;
    logic [63:0] e_data;
    bit   e_we [4];
    int   e_addr [4];
    s = int'(a[4]); tg = int'(a[7:5]); w = int'(a[3]);
    e_hit = 1'b0; vic = 0; e_n = 0;
    for (int k = 0; k < 2; k++)
      if (m_val[s][k] && int'(m_tag[s][k]) == tg) begin e_hit = 1'b1; vic = k; end
    if (!e_hit) begin
      vic = !m_val[s][0] ? 0 : (!m_val[s][1] ? 1 : int'(m_old[s]));
      if (m_val[s][vic] && m_dirty[s][vic])
        for (int k = 0; k < 2; k++) begin
          e_we[e_n] = 1'b1;
          e_addr[e_n] = int'(m_tag[s][vic]) * 32 + s * 16 + k * 8;
          exp_mem[int'(m_tag[s][vic]) * 4 + s * 2 + k] = m_data[s][vic][k];
          e_n++;
        end
      for (int k = 0; k < 2; k++) begin
        e_we[e_n] = 1'b0;
        e_addr[e_n] = tg * 32 + s * 16 + k * 8;
        m_data[s][vic][k] = exp_mem[tg * 4 + s * 2 + k];
        e_n++;
      end
      m_tag[s][vic] = 3'(tg); m_val[s][vic] = 1'b1; m_dirty[s][vic] = 1'b0;
      m_old[s] = ~m_old[s];
    end
    if (wr) begin m_data[s][vic][w] = wd; m_dirty[s][vic] = 1'b1; end
    e_data = m_data[s][vic][w];

    @(negedge clk);
    start = log_n;
    req_valid = 1'b1; req_write = wr; req_addr = 32'(a); req_wdata = wd;
    n = 0; rdy_bad = 1'b0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      n++;
      if (!resp_valid && req_ready) rdy_bad = 1'b1;
    end while (!resp_valid && n < 1000);
    got_hit = resp_hit;

    check(n < 1000, "R11", "response arrives", 64'(n), 64'd0);
    check(resp_hit == e_hit, wr ? (e_hit ? "R5" : "R6") : (e_hit ? "R3" : "R4"),
          "hit flag", 64'(resp_hit), 64'(e_hit));
    if (!wr) check(resp_rdata == e_data, e_hit ? "R3" : "R4", "load data", resp_rdata, e_data);
    if (e_hit) check(n == 2, "R3", "hit latency", 64'(n), 64'd2);
    check(!rdy_bad, "R11", "ready low while busy", 64'(rdy_bad), 64'd0);
    check(log_n - start == e_n, e_hit ? (wr ? "R5" : "R3") : "R9",
          "memory transfer count", 64'(log_n - start), 64'(e_n));
    if (log_n - start == e_n)
      for (int i = 0; i < e_n; i++)
        check(log_we[(start + i) % 16] == e_we[i] && int'(log_addr[(start + i) % 16]) == e_addr[i],
              e_we[i] ? "R9" : (wr ? "R6" : "R4"), "memory transfer kind/address",
              {55'd0, log_we[(start + i) % 16], log_addr[(start + i) % 16]},
              {55'd0, e_we[i], 8'(e_addr[i])});
    @(negedge clk);
    check(!resp_valid && req_ready, "R11", "single response pulse",
          {62'd0, resp_valid, req_ready}, 64'b01);
  endtask

  // watchdog: a hung run still ends with the summary
  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL R11 watchdog expired: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    bit h;
    logic [31:0] lfsr;
    logic [63:0] f0;
    do_reset();

    // R1: nothing is valid after reset
    do_req(1'b0, 8'h00, '0, h);
    check(h == 1'b0, "R1", "first access misses", 64'(h), 64'd0);

    // scaling loop over a strided array, word at 0 reused every pass
    do_reset();
    for (int x = 16; x < 80; x += 8) begin
      do_req(1'b0, 8'h00, '0, h);
      f0 = resp_rdata;
      do_req(1'b0, 8'(x), '0, h);
      do_req(1'b1, 8'(x), resp_rdata + f0, h);
    end

    // R7 / R8: fill order and first-in-first-out victim in set 0
    do_reset();
    do_req(1'b0, 8'h00, '0, h);                         // A -> way 0
    do_req(1'b0, 8'h20, '0, h);                         // B -> way 1
    do_req(1'b0, 8'h08, '0, h); check(h, "R7", "A resident", 64'(h), 64'd1);
    do_req(1'b0, 8'h28, '0, h); check(h, "R7", "B resident", 64'(h), 64'd1);
    do_req(1'b0, 8'h00, '0, h); check(h, "R8", "A hit again", 64'(h), 64'd1);
    do_req(1'b0, 8'h40, '0, h); check(!h, "R8", "C misses", 64'(h), 64'd0);
    do_req(1'b0, 8'h20, '0, h); check(h, "R8", "B kept though older in use", 64'(h), 64'd1);
    do_req(1'b0, 8'h00, '0, h); check(!h, "R8", "A evicted as first filled", 64'(h), 64'd0);

    // R5 / R6 / R9: store allocation and dirty writeback
    do_reset();
    do_req(1'b1, 8'h08, 64'hDEAD_BEEF_0000_0001, h);    // store miss, allocate
    check(!h, "R6", "store miss reported", 64'(h), 64'd0);
    do_req(1'b0, 8'h08, '0, h);
    check(h && resp_rdata == 64'hDEAD_BEEF_0000_0001, "R6", "merged word readable",
          resp_rdata, 64'hDEAD_BEEF_0000_0001);
    do_req(1'b1, 8'h00, 64'h1234_5678_9ABC_DEF0, h);    // store hit
    check(h, "R5", "store hit reported", 64'(h), 64'd1);
    check(mem[0] == init_word(0) && mem[1] == init_word(1), "R5", "memory untouched by store",
          mem[1], init_word(1));
    do_req(1'b0, 8'h28, '0, h);                         // clean fill of way 1
    do_req(1'b0, 8'h48, '0, h);                         // evict dirty way 0
    check(mem[1] == 64'hDEAD_BEEF_0000_0001 && mem[0] == 64'h1234_5678_9ABC_DEF0, "R9",
          "victim written back", mem[1], 64'hDEAD_BEEF_0000_0001);

    // near-exhaustive sweep over all 32 words with varying memory latency
    do_reset();
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 700; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lat = int'(lfsr[9:8]);
      do_req(lfsr[3], {lfsr[16:12], 3'b000}, {lfsr, ~lfsr} ^ 64'(i), h);
    end

    for (int i = 0; i < 32; i++)
      check(mem[i] == exp_mem[i], "R9", "memory image after sweep", mem[i], exp_mem[i]);
    check(hold_viol == 0, "R10", "request held until acknowledge", 64'(hold_viol), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule